// File: doc/BRIEF.md
# Event Timer Main Counter and Global Register Block

This block is the shared core of a multi-channel event timer. It owns the 64-bit main counter, which advances by one on every tick-enable pulse while the timer is globally enabled. It also owns the global register space behind a 32-bit register bus. It decodes a 1 KiB address window and serves a capability word, a global configuration word, an interrupt status word and the two halves of the counter. Accesses that land in the per-channel part of the window are passed to the comparator channels, and their read data is passed back.

The channel blocks compare against the counter value that this block drives out. They report interrupt events on `ch_irq_set`. The block collects these events into a write-1-to-clear status word. When software clears a status bit, the block sends a one-cycle pulse on `ch_irq_clr` so the channel can drop its interrupt. Clearing the global enable freezes the counter at its current value, and setting it again resumes counting from that value. Software can write either half of the counter at any time, including while it runs.

Read data returns one clock after the read request and reflects the state in the request cycle. Each 64-bit quantity is reached only as two separate 32-bit words: the low word first, and the high word at offset +4.

Top module: `etmr_regs`

## Requirements
- R1: After reset, the counter, the global configuration (enable and legacy bits) and the interrupt status are all zero, and `glb_en`, `legacy_en`, `irq_status` and `cnt_value` read zero.
- R2: A read at byte offset 0x000 returns {VENDOR_ID[15:0] at bits 31:16, 1 at bit 15 (legacy replacement capable), 0 at bit 14, 1 at bit 13 (64-bit counter), NUM_CH-1 at bits 12:8, REV_ID at bits 7:0}. A read at 0x004 returns PERIOD_FS, the tick period in femtoseconds. Writes to either word change nothing.
- R3: The configuration word at 0x010 has bit 0 = global enable (driven on `glb_en`) and bit 1 = legacy replacement (driven on `legacy_en`). All other bits read zero and ignore writes. The word at 0x014 reads zero and ignores writes.
- R4: While enabled, the counter rises by exactly one on each clock with `tick_en` high, and holds on each clock with `tick_en` low.
- R5: While disabled, the counter holds its value regardless of `tick_en`. After re-enabling, counting resumes from the held value.
- R6: The counter low word is at 0x0F0 and the high word at 0x0F4. Both are writable whether the counter is enabled or not. A write replaces only the addressed half, and in that clock the write takes precedence over a tick. A carry out of the low word propagates into the high word, and the full 64-bit value wraps to zero.
- R7: The status word at 0x020 holds bit i set by a pulse on `ch_irq_set[i]`. A write clears the bits that are written as 1 and are currently set. In the same clock, `ch_irq_clr` pulses for exactly those bits. A set arriving in the same clock as its clear wins, so the bit stays set and no clear pulse is sent for it. Written bits at or above NUM_CH have no effect.
- R8: An access in 0x100..0x3FF with channel index (addr-0x100)/0x20 below NUM_CH raises `ch_acc_vld` combinationally. It carries that index on `ch_idx`, addr[4:0] on `ch_off`, the write flag on `ch_acc_wr` and the write data on `ch_wdata`. A read returns `ch_rdata` sampled in the request clock.
- R9: A read of an unmapped offset, a misaligned offset (addr[1:0] non-zero), or a channel index at or above NUM_CH returns zero. A write to any of these changes no register and raises no `ch_acc_vld`.
- R10: A read request produces `rsp_vld` high for one clock on the next clock, together with `rsp_rdata`. A write request or an idle cycle leaves `rsp_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter tick-enable pulse |
| req_vld | input | 1 | Register access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_vld | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ch_acc_vld | output | 1 | Channel access strobe |
| ch_acc_wr | output | 1 | Channel access is a write |
| ch_idx | output | 5 | Channel index |
| ch_off | output | 5 | Byte offset inside the channel slot |
| ch_wdata | output | 32 | Channel write data |
| ch_rdata | input | 32 | Channel read data |
| ch_irq_set | input | NUM_CH | Per-channel interrupt event pulses |
| ch_irq_clr | output | NUM_CH | Per-channel interrupt clear pulses |
| irq_status | output | NUM_CH | Interrupt status bits |
| cnt_value | output | 64 | Main counter value |
| glb_en | output | 1 | Global enable |
| legacy_en | output | 1 | Legacy replacement control |

## Verification
The hardest case to reach is a clash between a tick and a bus event in the same clock. This covers a counter-half write landing on a tick, and a channel event arriving in the same clock as the software clear of that status bit. The bench holds `tick_en` high across the write clock and releases it on the following falling edge. This makes the number of counted ticks exact, so the expected counter value is known to the unit. It also drives `ch_irq_set` and the status write together on one falling edge. The bench additionally sweeps every word address in the window and every pairing of 4-bit set and clear patterns.

// File: rtl/etmr_pkg.sv
package etmr_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int CH_OFF_W = 5;
  localparam int CH_IDX_W = ADDR_W - CH_OFF_W;

  localparam logic [ADDR_W-1:0] OFS_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 10'h020;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] CH_BASE    = 10'h100;
  localparam logic [CH_IDX_W-1:0] CH_BASE_BLK = CH_IDX_W'(CH_BASE >> CH_OFF_W);

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LEG_BIT = 1;
  localparam int CFG_W       = 2;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CAP_LO,
    RG_CAP_HI,
    RG_CFG_LO,
    RG_STAT,
    RG_CNT_LO,
    RG_CNT_HI,
    RG_CHAN
  } reg_sel_e;
endpackage

// File: rtl/etmr_rst_sync.sv
module etmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/etmr_addr_dec.sv
module etmr_addr_dec
  import etmr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output reg_sel_e            sel_o,
  output logic [CH_IDX_W-1:0] idx_o,
  output logic [CH_OFF_W-1:0] off_o
);
  logic [CH_IDX_W-1:0] blk;
  logic                aligned;
  logic                in_win;
  logic                in_range;

  assign blk      = addr_i[ADDR_W-1:CH_OFF_W];
  assign idx_o    = blk - CH_BASE_BLK;
  assign off_o    = addr_i[CH_OFF_W-1:0];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_win   = (addr_i >= CH_BASE);
  assign in_range = (32'(idx_o) < NUM_CH);

  always_comb begin
    sel_o = RG_NONE;
    if (aligned) begin
      if (in_win) begin
        if (in_range) sel_o = RG_CHAN;
      end else begin
        case (addr_i)
          OFS_CAP_LO: sel_o = RG_CAP_LO;
          OFS_CAP_HI: sel_o = RG_CAP_HI;
          OFS_CFG_LO: sel_o = RG_CFG_LO;
          OFS_STAT:   sel_o = RG_STAT;
          OFS_CNT_LO: sel_o = RG_CNT_LO;
          OFS_CNT_HI: sel_o = RG_CNT_HI;
          default:    sel_o = RG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/etmr_main_cnt.sv
module etmr_main_cnt #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [2*HALF_W-1:0] cnt_o
);
  localparam int CW = 2 * HALF_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_ld;
  logic          any_wr;

  assign any_wr = wr_lo_i | wr_hi_i;
  assign cnt_ld = any_wr | (en_i & tick_i);

  always_comb begin
    cnt_d = cnt_q;
    if (any_wr) begin
      if (wr_lo_i) cnt_d[HALF_W-1:0]  = wdata_i;
      if (wr_hi_i) cnt_d[CW-1:HALF_W] = wdata_i;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R5: frozen without enable and without a write
  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !any_wr) |=> $stable(cnt_q));

  // R4: one step per tick while enabled
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !any_wr) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R6: a low-half write leaves the high half untouched
  p_lo_wr_keeps_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && !wr_hi_i) |=> (cnt_q[CW-1:HALF_W] == $past(cnt_q[CW-1:HALF_W])));
endmodule

// File: rtl/etmr_isr.sv
module etmr_isr #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] clr_o,
  output logic [NUM_CH-1:0] isr_o
);
  logic [NUM_CH-1:0] isr_q;
  logic [NUM_CH-1:0] isr_d;
  logic              isr_ld;

  assign clr_o  = clr_wr_i ? (wdata_i & isr_q & ~set_i) : '0;
  assign isr_ld = (|set_i) | clr_wr_i;

  always_comb begin
    isr_d = (isr_q & ~clr_o) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_ld) isr_q <= isr_d;
  end

  assign isr_o = isr_q;

  // R7: an event always leaves its bit set
  p_set_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((isr_q & $past(set_i)) == $past(set_i)));

  // R7: written ones without a coincident event end up clear
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((isr_q & $past(wdata_i & ~set_i)) == '0));

  // R7: clear pulses only name bits that were set
  p_clr_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_o & ~isr_q) == '0));
endmodule

// File: rtl/etmr_regs.sv
module etmr_regs
  import etmr_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter logic [31:0] PERIOD_FS = 32'd69841279,
  parameter logic [15:0] VENDOR_ID = 16'h1D0F,
  parameter logic [7:0]  REV_ID    = 8'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                req_vld,
  input  logic                req_wr,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_vld,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                ch_acc_vld,
  output logic                ch_acc_wr,
  output logic [CH_IDX_W-1:0] ch_idx,
  output logic [CH_OFF_W-1:0] ch_off,
  output logic [DATA_W-1:0]   ch_wdata,
  input  logic [DATA_W-1:0]   ch_rdata,
  input  logic [NUM_CH-1:0]   ch_irq_set,
  output logic [NUM_CH-1:0]   ch_irq_clr,
  output logic [NUM_CH-1:0]   irq_status,
  output logic [2*DATA_W-1:0] cnt_value,
  output logic                glb_en,
  output logic                legacy_en
);
  localparam logic [DATA_W-1:0] CAP_LO =
    {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), REV_ID};

  logic              rst_sn;
  reg_sel_e          sel;
  logic              rd_req;
  logic              wr_req;
  logic              cfg_wr;
  logic [CFG_W-1:0]  cfg_q;
  logic [CFG_W-1:0]  cfg_d;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rsp_data_q;
  logic [DATA_W-1:0] rsp_data_d;
  logic              rsp_vld_q;

  etmr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  etmr_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i (req_addr),
    .sel_o  (sel),
    .idx_o  (ch_idx),
    .off_o  (ch_off)
  );

  assign rd_req = req_vld & ~req_wr;
  assign wr_req = req_vld &  req_wr;
  assign cfg_wr = wr_req & (sel == RG_CFG_LO);

  // Channel forwarding
  assign ch_acc_vld = req_vld & (sel == RG_CHAN);
  assign ch_acc_wr  = req_wr;
  assign ch_wdata   = req_wdata;

  // Global configuration
  always_comb begin
    cfg_d = req_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_d;
  end

  assign glb_en    = cfg_q[CFG_EN_BIT];
  assign legacy_en = cfg_q[CFG_LEG_BIT];

  etmr_main_cnt #(.HALF_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sn),
    .en_i    (glb_en),
    .tick_i  (tick_en),
    .wr_lo_i (wr_req & (sel == RG_CNT_LO)),
    .wr_hi_i (wr_req & (sel == RG_CNT_HI)),
    .wdata_i (req_wdata),
    .cnt_o   (cnt_value)
  );

  etmr_isr #(.NUM_CH(NUM_CH)) u_isr (
    .clk      (clk),
    .rst_n    (rst_sn),
    .set_i    (ch_irq_set),
    .clr_wr_i (wr_req & (sel == RG_STAT)),
    .wdata_i  (req_wdata[NUM_CH-1:0]),
    .clr_o    (ch_irq_clr),
    .isr_o    (irq_status)
  );

  // Read path
  always_comb begin
    rd_mux = '0;
    case (sel)
      RG_CAP_LO: rd_mux = CAP_LO;
      RG_CAP_HI: rd_mux = PERIOD_FS;
      RG_CFG_LO: rd_mux[CFG_W-1:0] = cfg_q;
      RG_STAT:   rd_mux[NUM_CH-1:0] = irq_status;
      RG_CNT_LO: rd_mux = cnt_value[DATA_W-1:0];
      RG_CNT_HI: rd_mux = cnt_value[2*DATA_W-1:DATA_W];
      RG_CHAN:   rd_mux = ch_rdata;
      default:   rd_mux = '0;
    endcase
  end

  always_comb begin
    rsp_data_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_vld_q  <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      rsp_vld_q <= rd_req;
      if (rd_req) rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_vld   = rsp_vld_q;
  assign rsp_rdata = rsp_data_q;

  // R10: a read is answered on the next clock
  p_rsp_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_req |=> rsp_vld);

  // R10: no response without a read
  p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_req |=> !rsp_vld);

  // R8: forwarded index always names an existing channel
  p_fwd_range_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    ch_acc_vld |-> (32'(ch_idx) < NUM_CH));

  // R3: configuration moves only on a write to its word
  p_cfg_stable_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    !cfg_wr |=> $stable(cfg_q));
endmodule

// File: tb/tb_etmr_regs.sv
`timescale 1ns/1ps
module tb_etmr_regs;
  localparam int          NCH = 4;
  localparam logic [31:0] PER = 32'd69841279;
  localparam logic [15:0] VID = 16'h1D0F;
  localparam logic [7:0]  RID = 8'h01;
  localparam logic [31:0] CAP_EXP = {VID, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), RID};

  logic clk = 1'b0;
  logic rst_n;
  logic tick_en;
  logic req_vld, req_wr;
  logic [9:0] req_addr;
  logic [31:0] req_wdata;
  logic rsp_vld;
  logic [31:0] rsp_rdata;
  logic ch_acc_vld, ch_acc_wr;
  logic [4:0] ch_idx, ch_off;
  logic [31:0] ch_wdata, ch_rdata;
  logic [NCH-1:0] ch_irq_set, ch_irq_clr, irq_status;
  logic [63:0] cnt_value;
  logic glb_en, legacy_en;

  int n_chk = 0;
  int n_fail = 0;

  logic       last_acc;
  logic       last_acc_wr;
  logic [4:0] last_idx, last_off;
  logic [31:0] last_wd;
  logic [NCH-1:0] last_clr;

  always #2 clk = ~clk;

  assign ch_rdata = ch_acc_vld ? {8'hC5, 3'b000, ch_idx, 11'b0, ch_off} : 32'hDEAD_BEEF;

  etmr_regs #(.NUM_CH(NCH), .PERIOD_FS(PER), .VENDOR_ID(VID), .REV_ID(RID)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata),
    .ch_acc_vld(ch_acc_vld), .ch_acc_wr(ch_acc_wr), .ch_idx(ch_idx), .ch_off(ch_off),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .ch_irq_set(ch_irq_set), .ch_irq_clr(ch_irq_clr), .irq_status(irq_status),
    .cnt_value(cnt_value), .glb_en(glb_en), .legacy_en(legacy_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    req_vld = 1'b1; req_wr = 1'b0; req_addr = a; req_wdata = 32'h0;
    #1;
    last_acc = ch_acc_vld; last_idx = ch_idx; last_off = ch_off;
    @(negedge clk);
    req_vld = 1'b0;
    chk("R10 rsp_vld after read", {63'b0, rsp_vld}, 64'd1);
    d = rsp_rdata;
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    #1;
    last_acc = ch_acc_vld; last_acc_wr = ch_acc_wr; last_idx = ch_idx;
    last_off = ch_off; last_wd = ch_wdata; last_clr = ch_irq_clr;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0;
    if (rsp_vld !== 1'b0) begin
      n_chk++; n_fail++;
      $display("FAIL R10 rsp_vld after write act=1 exp=0");
    end
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic logic [31:0] exp_rd0(input int a);
    logic [31:0] r;
    r = 32'h0;
    if (a[1:0] == 2'b00) begin
      if (a == 0) r = CAP_EXP;
      else if (a == 4) r = PER;
      else if (a >= 256 && ((a - 256) / 32) < NCH)
        r = {8'hC5, 3'b000, 5'((a - 256) / 32), 11'b0, 5'(a % 32)};
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lo, hi;
    rst_n = 1'b0; tick_en = 1'b0; req_vld = 1'b0; req_wr = 1'b0;
    req_addr = '0; req_wdata = '0; ch_irq_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cnt_value", cnt_value, 64'd0);
    chk("R1 glb_en", {63'b0, glb_en}, 64'd0);
    chk("R1 legacy_en", {63'b0, legacy_en}, 64'd0);
    chk("R1 irq_status", 64'(irq_status), 64'd0);
    chk("R1 rsp_vld idle", {63'b0, rsp_vld}, 64'd0);

    // R2 R3 R8 R9: sweep every word in the window from reset state
    for (int a = 0; a < 1024; a += 4) begin
      bus_rd(10'(a), d);
      chk($sformatf("R9/R2/R8 read 0x%03h", a), 64'(d), 64'(exp_rd0(a)));
      chk($sformatf("R8 forward flag 0x%03h", a), {63'b0, last_acc},
          {63'b0, (a >= 256 && ((a - 256) / 32) < NCH)});
    end
    bus_rd(10'h001, d); chk("R9 misaligned read", 64'(d), 64'd0);
    bus_rd(10'h102, d); chk("R9 misaligned chan read", 64'(d), 64'd0);
    chk("R9 misaligned no forward", {63'b0, last_acc}, 64'd0);
    bus_rd(10'h164, d); chk("R8 chan idx", 64'(last_idx), 64'd3);
    chk("R8 chan off", 64'(last_off), 64'd4);

    // R2 R3 R9: writes to read-only / unmapped words have no effect
    bus_wr(10'h000, 32'hFFFF_FFFF);
    bus_wr(10'h004, 32'h1234_5678);
    bus_wr(10'h014, 32'hFFFF_FFFF);
    bus_wr(10'h008, 32'hFFFF_FFFF);
    bus_wr(10'h030, 32'hFFFF_FFFF);
    bus_wr(10'h0F1, 32'hFFFF_FFFF);
    bus_wr(10'h180, 32'hFFFF_FFFF);
    chk("R9 out-of-range chan write no forward", {63'b0, last_acc}, 64'd0);
    bus_wr(10'h3FC, 32'hFFFF_FFFF);
    chk("R9 top chan write no forward", {63'b0, last_acc}, 64'd0);
    bus_rd(10'h000, d); chk("R2 cap lo after write", 64'(d), 64'(CAP_EXP));
    bus_rd(10'h004, d); chk("R2 cap hi after write", 64'(d), 64'(PER));
    bus_rd(10'h014, d); chk("R3 cfg hi reads zero", 64'(d), 64'd0);
    bus_rd(10'h010, d); chk("R9 cfg untouched", 64'(d), 64'd0);
    bus_rd(10'h020, d); chk("R9 status untouched", 64'(d), 64'd0);
    chk("R9 counter untouched", cnt_value, 64'd0);

    // R8 channel write forwarding
    bus_wr(10'h164, 32'hA5A5_0001);
    chk("R8 wr forward", {63'b0, last_acc}, 64'd1);
    chk("R8 wr flag", {63'b0, last_acc_wr}, 64'd1);
    chk("R8 wr idx", 64'(last_idx), 64'd3);
    chk("R8 wr off", 64'(last_off), 64'd4);
    chk("R8 wr data", 64'(last_wd), 64'hA5A5_0001);

    // R3 configuration bits
    bus_wr(10'h010, 32'hFFFF_FFFC);
    bus_rd(10'h010, d); chk("R3 masked bits", 64'(d), 64'd0);
    bus_wr(10'h010, 32'h0000_0002);
    bus_rd(10'h010, d); chk("R3 legacy bit", 64'(d), 64'd2);
    chk("R3 legacy_en port", {63'b0, legacy_en}, 64'd1);
    chk("R3 glb_en port", {63'b0, glb_en}, 64'd0);
    bus_wr(10'h010, 32'h0000_0001);
    chk("R3 glb_en set", {63'b0, glb_en}, 64'd1);
    chk("R3 legacy cleared", {63'b0, legacy_en}, 64'd0);

    // R4 counting
    ticks(10);
    bus_rd(10'h0F0, d); chk("R4 ten ticks", 64'(d), 64'd10);
    for (int i = 0; i < 10; i++) begin
      tick_en = 1'b1; @(negedge clk);
      tick_en = 1'b0; @(negedge clk);
    end
    chk("R4 alternating ticks", cnt_value, 64'd20);

    // R5 hold while disabled, resume after
    bus_wr(10'h010, 32'h0);
    ticks(15);
    chk("R5 frozen port", cnt_value, 64'd20);
    bus_rd(10'h0F0, d); chk("R5 frozen read", 64'(d), 64'd20);
    bus_wr(10'h010, 32'h1);
    ticks(5);
    bus_rd(10'h0F0, d); chk("R5 resumed", 64'(d), 64'd25);

    // R6 carry and wrap
    bus_wr(10'h010, 32'h0);
    bus_wr(10'h0F0, 32'hFFFF_FFFE);
    bus_wr(10'h0F4, 32'h0000_0012);
    bus_rd(10'h0F0, lo); bus_rd(10'h0F4, hi);
    chk("R6 written while off", {hi, lo}, 64'h0000_0012_FFFF_FFFE);
    bus_wr(10'h010, 32'h1);
    ticks(3);
    bus_rd(10'h0F0, lo); bus_rd(10'h0F4, hi);
    chk("R6 carry into high", {hi, lo}, 64'h0000_0013_0000_0001);
    bus_wr(10'h010, 32'h0);
    bus_wr(10'h0F0, 32'hFFFF_FFFF);
    bus_wr(10'h0F4, 32'hFFFF_FFFF);
    bus_wr(10'h010, 32'h1);
    ticks(1);
    chk("R6 64-bit wrap", cnt_value, 64'd0);

    // R6 writes while running, write beats tick in its clock
    bus_wr(10'h010, 32'h0);
    bus_wr(10'h0F4, 32'h0000_0007);
    bus_wr(10'h010, 32'h1);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr(10'h0F0, 32'h0000_0100);
    tick_en = 1'b0;
    chk("R6 lo write while running", cnt_value, 64'h0000_0007_0000_0100);
    tick_en = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr(10'h0F4, 32'h0000_0ABC);
    tick_en = 1'b0;
    bus_rd(10'h0F0, lo); bus_rd(10'h0F4, hi);
    chk("R6 hi write while running", {hi, lo}, 64'h0000_0ABC_0000_0102);
    bus_wr(10'h010, 32'h0);

    // R7 status: every set pattern against every clear pattern
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 16; w++) begin
        ch_irq_set = NCH'(s); @(negedge clk); ch_irq_set = '0;
        bus_wr(10'h020, 32'hFFFF_FFF0 & 32'h7FFF_FFF0 | 32'(w));
        chk($sformatf("R7 clr pulse s=%0d w=%0d", s, w), 64'(last_clr), 64'(s & w));
        chk($sformatf("R7 status s=%0d w=%0d", s, w), 64'(irq_status), 64'(s & ~w & 15));
        bus_rd(10'h020, d);
        chk($sformatf("R7 status read s=%0d w=%0d", s, w), 64'(d), 64'(s & ~w & 15));
        bus_wr(10'h020, 32'hF);
      end
    end
    chk("R7 all cleared", 64'(irq_status), 64'd0);

    // R7 set and clear in the same clock: set wins
    ch_irq_set = 4'b0001; @(negedge clk); ch_irq_set = '0;
    ch_irq_set = 4'b0001;
    bus_wr(10'h020, 32'h1);
    ch_irq_set = '0;
    chk("R7 same-clock set wins, no pulse", 64'(last_clr), 64'd0);
    chk("R7 same-clock set wins, bit kept", 64'(irq_status), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule